// File: doc/BRIEF.md
# Cross-Domain Busy-Flagged Control Register

This block is an 8-bit power-reduction control register on a CPU-side register bus. Four writable bits switch off parts of a receiver: temperature measurement, the channel filter, path A and path B. A 1 means the function is off. These bits are carried into a receive clock domain that runs asynchronously to the CPU clock. The transfer uses a push handshake. A toggle request goes across through two flip-flops, and a toggle acknowledge comes back the same way. The value being sent sits in a CPU-side holding register that does not change while the transfer is open.

Software reads a busy flag in bit 7. A write is taken only while busy is 0. Each accepted write raises busy, and busy stays high until the receive domain has the new word. Bits 6 to 4 carry status from the receive side, synchronized into the CPU clock. There is one way to abort an open transfer: drop the global receiver enable. Doing so also puts the register back to its reset contents.

Top module: `xdom_ctrl_reg`

## Requirements
- R1: After reset, busy is 0 and `rx_cfg` is 4'hF. A read returns 8'h0F while `rx_status` is 0: bits 3:0 are the controls, which reset to 1, and the status bits are 0.
- R2: A write while busy is 0 and `rx_enable` is 1 is accepted. It stores `wr_data[3:0]` as the control bits, ignores `wr_data[7:4]`, and busy reads 1 from the next CPU cycle.
- R3: A write while busy is 1 is ignored. The stored bits and the value later delivered to `rx_cfg` are those of the earlier accepted write.
- R4: Busy rises only after an accepted write. It falls only after the receive domain has captured the word, so `rx_cfg` equals the last accepted control bits from the cycle busy reads 0.
- R5: The holding register does not change while busy is 1. `rx_cfg` only ever changes to the held value, except on reset.
- R6: With `rx_enable` at 0, the following all hold:
  - `rx_cfg` is forced to 4'hF at once.
  - From the next CPU cycle busy is 0 and the control bits read 4'hF, which aborts any open transfer.
  - Writes are ignored.
- R7: While `rd_en` is 1, `rd_data` is {busy, status[2:0], control[3:0]}. The status bits follow `rx_status` within three CPU cycles. While `rd_en` is 0, `rd_data` is 0.
- R8: After an abort and re-enable, a new write completes normally and is delivered to `rx_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-side clock |
| cpu_rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one CPU cycle per write |
| wr_data | input | 8 | Write data; bits 3:0 are used |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data: {busy, status, controls} |
| busy | output | 1 | High while a transfer is open |
| rx_enable | input | 1 | Global receiver enable; low aborts and clears |
| rx_clk | input | 1 | Receive-domain clock, asynchronous to cpu_clk |
| rx_status | input | 3 | Read-only status from the receive domain |
| rx_cfg | output | 4 | Control word as applied in the receive domain |

## Verification
After a write cycle, busy is registered and reads 1 one CPU cycle later. The delivered word and the fall of busy depend on the ratio of the two clocks. The request passes three receive flops, and the acknowledge passes two CPU flops plus one more CPU flop for busy. For that reason the bench does not sample a fixed cycle. It polls busy on each falling CPU edge up to a 16-cycle bound, then checks `rx_cfg` and the read value.

Status bits are sampled three CPU cycles after `rx_status` changes. Abort effects are sampled one CPU cycle after `rx_enable` falls, except `rx_cfg`, which is checked right away because its clear is asynchronous.

// File: rtl/xdom_ctrl_pkg.sv
package xdom_ctrl_pkg;
    localparam int CTRL_W = 4;
    localparam int STAT_W = 3;
    localparam int SYNC_STAGES = 2;
    localparam logic [CTRL_W-1:0] CTRL_RST = '1;

    typedef struct packed {
        logic [CTRL_W-1:0] hold;
        logic              busy;
        logic              req;
        logic              ack_seen;
    } cpu_state_t;

    typedef struct packed {
        logic [CTRL_W-1:0] cfg;
        logic              ack;
    } rx_state_t;

    localparam cpu_state_t CPU_RST = '{hold: CTRL_RST, busy: 1'b0, req: 1'b0, ack_seen: 1'b0};
    localparam rx_state_t  RX_RST  = '{cfg: CTRL_RST, ack: 1'b0};
endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (clr) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xdom_cpu_side.sv
module xdom_cpu_side
    import xdom_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic              ack_sync,
    output logic [CTRL_W-1:0] hold,
    output logic              busy,
    output logic              req
);
    cpu_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = CPU_RST;
        end else begin
            state_d.ack_seen = ack_sync;
            if (state_q.busy && (ack_sync != state_q.ack_seen)) begin
                state_d.busy = 1'b0;
            end
            if (wr_en && !state_q.busy) begin
                state_d.hold = wr_ctrl;
                state_d.busy = 1'b1;
                state_d.req  = ~state_q.req;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CPU_RST;
        else        state_q <= state_d;
    end

    assign hold = state_q.hold;
    assign busy = state_q.busy;
    assign req  = state_q.req;
endmodule

// File: rtl/xdom_rx_side.sv
module xdom_rx_side
    import xdom_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              arst_n,
    input  logic              req_sync,
    input  logic [CTRL_W-1:0] hold,
    output logic [CTRL_W-1:0] cfg,
    output logic              ack
);
    rx_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.ack = req_sync;
        if (req_sync != state_q.ack) begin
            state_d.cfg = hold;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= RX_RST;
        else         state_q <= state_d;
    end

    assign cfg = state_q.cfg;
    assign ack = state_q.ack;
endmodule

// File: rtl/xdom_ctrl_reg.sv
module xdom_ctrl_reg
    import xdom_ctrl_pkg::*;
(
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              busy,
    input  logic              rx_enable,
    input  logic              rx_clk,
    input  logic [STAT_W-1:0] rx_status,
    output logic [CTRL_W-1:0] rx_cfg
);
    logic [CTRL_W-1:0] hold_w;
    logic              req_w, req_rx, ack_w, ack_cpu;
    logic [STAT_W-1:0] stat_cpu;
    logic              rx_arst_n;

    assign rx_arst_n = cpu_rst_n & rx_enable;

    xdom_cpu_side u_cpu (
        .clk      (cpu_clk),
        .rst_n    (cpu_rst_n),
        .enable   (rx_enable),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_data[CTRL_W-1:0]),
        .ack_sync (ack_cpu),
        .hold     (hold_w),
        .busy     (busy),
        .req      (req_w)
    );

    xdom_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (rx_clk),
        .rst_n (rx_arst_n),
        .clr   (1'b0),
        .d     (req_w),
        .q     (req_rx)
    );

    xdom_rx_side u_rx (
        .clk      (rx_clk),
        .arst_n   (rx_arst_n),
        .req_sync (req_rx),
        .hold     (hold_w),
        .cfg      (rx_cfg),
        .ack      (ack_w)
    );

    xdom_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .clr   (~rx_enable),
        .d     (ack_w),
        .q     (ack_cpu)
    );

    xdom_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) u_stat_sync (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .clr   (~rx_enable),
        .d     (rx_status),
        .q     (stat_cpu)
    );

    assign rd_data = rd_en ? {busy, stat_cpu, hold_w} : 8'h00;
endmodule

// File: rtl/xdom_ctrl_reg_chk.sv
module xdom_ctrl_reg_chk (
    input logic       cpu_clk,
    input logic       cpu_rst_n,
    input logic       rx_clk,
    input logic       rx_arst_n,
    input logic       rx_enable,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic [3:0] hold,
    input logic [3:0] rx_cfg
);
    // R2: an accepted write raises busy on the next cycle
    p_busy_rise_r2: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (wr_en && !busy && rx_enable) |=> busy);

    // R4: busy never rises without an accepted write
    p_busy_only_on_write_r4: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (!busy && !(wr_en && rx_enable)) |=> !busy);

    // R3 and R5: holding register frozen while a transfer is open
    p_hold_stable_r5: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (busy && rx_enable) |=> $stable(hold));

    // R6: dropping the enable aborts and clears
    p_abort_clear_r6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        !rx_enable |=> (!busy && hold == 4'hF));

    // R5: the receive side only ever takes the held word
    p_rx_from_hold_r5: assert property (@(posedge rx_clk) disable iff (!rx_arst_n)
        !$stable(rx_cfg) |-> (rx_cfg == hold));

    // R7: an idle read port shows zero
    always_comb begin
        if (cpu_rst_n && !rd_en) begin
            p_idle_read_zero_r7: assert (rd_data == 8'h00);
        end
    end
endmodule

bind xdom_ctrl_reg xdom_ctrl_reg_chk u_chk (
    .cpu_clk   (cpu_clk),
    .cpu_rst_n (cpu_rst_n),
    .rx_clk    (rx_clk),
    .rx_arst_n (rx_arst_n),
    .rx_enable (rx_enable),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .busy      (busy),
    .hold      (hold_w),
    .rx_cfg    (rx_cfg)
);

// File: tb/tb_xdom_ctrl_reg.sv
`timescale 1ns/1ps
module tb_xdom_ctrl_reg;
    logic       cpu_clk = 1'b0;
    logic       rx_clk  = 1'b0;
    logic       cpu_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       busy;
    logic       rx_enable = 1'b1;
    logic [2:0] rx_status = 3'b000;
    logic [3:0] rx_cfg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5   cpu_clk = ~cpu_clk;
    always #3.5 rx_clk  = ~rx_clk;

    xdom_ctrl_reg dut (
        .cpu_clk   (cpu_clk),
        .cpu_rst_n (cpu_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .busy      (busy),
        .rx_enable (rx_enable),
        .rx_clk    (rx_clk),
        .rx_status (rx_status),
        .rx_cfg    (rx_cfg)
    );

    // write data, expected control bits (R2: upper nibble ignored)
    localparam logic [11:0] VEC [6] = '{
        {8'h05, 4'h5}, {8'h0A, 4'hA}, {8'hF0, 4'h0},
        {8'hA3, 4'h3}, {8'h0F, 4'hF}, {8'h6C, 4'hC}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge cpu_clk);
        rd_en = 1'b1;
        #1 v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge cpu_clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge cpu_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (busy && k < 16) begin
            @(negedge cpu_clk);
            k++;
        end
        chk(req, {7'd0, busy}, 8'h00);
    endtask

    logic [7:0] rv;

    initial begin
        repeat (3) @(negedge cpu_clk);
        cpu_rst_n = 1'b1;
        @(negedge cpu_clk);
        // R1 reset state
        chk("R1 busy", {7'd0, busy}, 8'h00);
        chk("R1 rx_cfg", {4'd0, rx_cfg}, 8'h0F);
        do_read(rv);
        chk("R1 read", rv, 8'h0F);
        // R7 idle read
        #1 chk("R7 idle rd_data", rd_data, 8'h00);

        // R2/R4 vector walk
        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i][11:4]);
            chk("R2 busy after write", {7'd0, busy}, 8'h01);
            do_read(rv);
            chk("R7 busy bit in read", {7'd0, rv[7]}, 8'h01);
            wait_idle("R4 busy clears");
            chk("R4 rx_cfg delivered", {4'd0, rx_cfg}, {4'd0, VEC[i][3:0]});
            do_read(rv);
            chk("R2 read controls", rv, {4'd0, VEC[i][3:0]});
        end

        // R3 write while busy ignored
        do_write(8'h09);
        @(negedge cpu_clk);
        wr_en = 1'b1; wr_data = 8'h06;
        @(negedge cpu_clk);
        wr_en = 1'b0;
        wait_idle("R3 busy clears");
        chk("R3 rx_cfg keeps first", {4'd0, rx_cfg}, 8'h09);
        do_read(rv);
        chk("R3 read keeps first", rv, 8'h09);
        repeat (10) @(negedge cpu_clk);
        chk("R3 no second transfer", {rx_cfg, 3'd0, busy}, 8'h90);

        // R7 status path
        rx_status = 3'b101;
        repeat (3) @(negedge cpu_clk);
        do_read(rv);
        chk("R7 status bits", rv, 8'h59);
        rx_status = 3'b000;
        repeat (3) @(negedge cpu_clk);

        // R6 abort during transfer
        do_write(8'h02);
        rx_enable = 1'b0;
        #1 chk("R6 rx_cfg forced", {4'd0, rx_cfg}, 8'h0F);
        @(negedge cpu_clk);
        chk("R6 busy dropped", {7'd0, busy}, 8'h00);
        do_read(rv);
        chk("R6 read cleared", rv, 8'h0F);
        do_write(8'h01);
        chk("R6 write ignored busy", {7'd0, busy}, 8'h00);
        do_read(rv);
        chk("R6 write ignored data", rv, 8'h0F);

        // R8 re-enable and transfer again
        @(negedge cpu_clk);
        rx_enable = 1'b1;
        repeat (4) @(negedge cpu_clk);
        do_write(8'h07);
        chk("R8 busy after write", {7'd0, busy}, 8'h01);
        wait_idle("R8 busy clears");
        chk("R8 rx_cfg delivered", {4'd0, rx_cfg}, 8'h07);

        // R1 asynchronous reset mid-operation
        do_write(8'h0B);
        cpu_rst_n = 1'b0;
        #1 chk("R1 reset rx_cfg", {4'd0, rx_cfg}, 8'h0F);
        chk("R1 reset busy", {7'd0, busy}, 8'h00);
        @(negedge cpu_clk);
        cpu_rst_n = 1'b1;
        do_read(rv);
        chk("R1 reset read", rv, 8'h0F);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge cpu_clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule